// File: doc/BRIEF.md
# Texel Colour Decoder with Transparency Key

This block turns a raw texel word, as returned by texture memory, into a uniform 32-bit colour with alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0 (8 bits each). A 3-bit depth code on the same cycle says how to read the word. Direct formats are widened to 8 bits per channel by copying each channel's top bits into its low bits. Palettized depths use the low bits of the word as an index into a 256-entry, 16-bit colour table. That table is filled through a simple write port, and its entries are read in one of three 16-bit layouts chosen by a 2-bit table-format code.

After decoding, an optional transparency key compares the 24 colour bits with a 24-bit key. On a match the alpha is forced to zero and a key-hit flag is raised, so that a filter further down can treat the texel as transparent. The result and the flag come out of registers one clock after the inputs are presented.

Top module: `texdec_top`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, `argb_o` is 0 and `key_hit_o` is 0.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge. They do not change between edges.
- R3: Depth code 3'b100 (565) decodes `texel_i[15:0]` as R[15:11], G[10:5], B[4:0]. Red and blue expand as {v,v[4:2]}, green as {v,v[5:4]}, and alpha is 8'hFF.
- R4: Depth code 3'b101 (1555) decodes A[15], R[14:10], G[9:5], B[4:0]. The alpha bit gives 8'h00 or 8'hFF, and each 5-bit channel expands as {v,v[4:2]}.
- R5: Depth code 3'b110 (4444) decodes A[15:12], R[11:8], G[7:4], B[3:0], and each nibble n expands to {n,n}.
- R6: Depth code 3'b111 passes `texel_i` through unchanged as ARGB.
- R7: Depth codes 3'b000, 3'b001, 3'b010 and 3'b011 are 1, 2, 4 and 8 bits per texel. The table index is the low 1, 2, 4 or 8 bits of `texel_i`, and all higher bits have no effect.
- R8: Table entries are decoded with `palfmt_i`: 2'b00 as 565 (R3 rules), 2'b01 as 1555 (R4 rules), 2'b10 as 4444 (R5 rules). 2'b11 is decoded as 565.
- R9: A write with `pal_we_i` high stores `pal_wdata_i` at `pal_waddr_i` on the clock edge, and lookups in later cycles return the new entry.
- R10: With `key_en_i` high and decoded bits 23:0 equal to `key_rgb_i`, the output alpha is 8'h00, the colour bits are kept, and `key_hit_o` is 1.
- R11: With `key_en_i` low, or with no match, the decoded colour passes through unchanged and `key_hit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| texel_i | input | 32 | Raw texel word |
| depth_i | input | 3 | Texel depth / format code |
| palfmt_i | input | 2 | Layout of the colour table entries |
| key_en_i | input | 1 | Transparency key enable |
| key_rgb_i | input | 24 | Key colour, RGB888 |
| pal_we_i | input | 1 | Colour table write enable |
| pal_waddr_i | input | 8 | Colour table write address |
| pal_wdata_i | input | 16 | Colour table write data |
| argb_o | output | 32 | Decoded ARGB8888 colour |
| key_hit_o | output | 1 | Texel matched the key |

## Verification
The bench fills the whole table with random entries. It then sends random words under every depth code and every table format, including the reserved one, so that wrong field positions or wrong replication in any layout show up. It also randomizes the bits above the index, which tells the index width of each palettized depth apart from a wider or narrower one. Keys are drawn either at random or set equal to the expected colour, with the enable both on and off, which separates a real match from a false hit and checks that a disabled key has no effect. Directed cases cover the reset state, a table write followed at once by a lookup of that entry, and the one-cycle latency.

// File: rtl/texdec_pkg.sv
package texdec_pkg;
  localparam int TEXEL_W    = 32;
  localparam int ENTRY_W    = 16;
  localparam int KEY_W      = 24;
  localparam int PAL_WORDS  = 256;
  localparam int PAL_IDX_W  = $clog2(PAL_WORDS);

  typedef enum logic [2:0] {
    DEP_P1   = 3'b000,
    DEP_P2   = 3'b001,
    DEP_P4   = 3'b010,
    DEP_P8   = 3'b011,
    DEP_565  = 3'b100,
    DEP_1555 = 3'b101,
    DEP_4444 = 3'b110,
    DEP_8888 = 3'b111
  } depth_e;

  typedef enum logic [1:0] {
    PF_565  = 2'b00,
    PF_1555 = 2'b01,
    PF_4444 = 2'b10,
    PF_RSVD = 2'b11
  } palfmt_e;

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] v);
    return {v, v};
  endfunction

  function automatic logic [31:0] from565(input logic [15:0] w);
    return {8'hFF, widen5(w[15:11]), widen6(w[10:5]), widen5(w[4:0])};
  endfunction

  function automatic logic [31:0] from1555(input logic [15:0] w);
    return {{8{w[15]}}, widen5(w[14:10]), widen5(w[9:5]), widen5(w[4:0])};
  endfunction

  function automatic logic [31:0] from4444(input logic [15:0] w);
    return {widen4(w[15:12]), widen4(w[11:8]), widen4(w[7:4]), widen4(w[3:0])};
  endfunction
endpackage

// File: rtl/texdec_palette.sv
module texdec_palette
  import texdec_pkg::*;
#(
  parameter int WORDS = PAL_WORDS,
  parameter int DW    = ENTRY_W,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] table_q [WORDS];

  always_ff @(posedge clk) begin
    if (we_i) table_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = table_q[raddr_i];

  // R9: an entry written on the last edge is returned when read now
  a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we_i) && !we_i && raddr_i == $past(waddr_i))
      |-> rdata_o == $past(wdata_i));
endmodule

// File: rtl/texdec_expand.sv
module texdec_expand
  import texdec_pkg::*;
(
  input  logic [TEXEL_W-1:0]   texel_i,
  input  depth_e               depth_i,
  input  palfmt_e              palfmt_i,
  input  logic [ENTRY_W-1:0]   entry_i,
  output logic [PAL_IDX_W-1:0] index_o,
  output logic [31:0]          argb_o
);
  logic [31:0] entry_argb;

  always_comb begin
    index_o = '0;
    unique case (depth_i)
      DEP_P1:  index_o[0]   = texel_i[0];
      DEP_P2:  index_o[1:0] = texel_i[1:0];
      DEP_P4:  index_o[3:0] = texel_i[3:0];
      default: index_o      = texel_i[PAL_IDX_W-1:0];
    endcase
  end

  always_comb begin
    unique case (palfmt_i)
      PF_1555: entry_argb = from1555(entry_i);
      PF_4444: entry_argb = from4444(entry_i);
      default: entry_argb = from565(entry_i);
    endcase
  end

  always_comb begin
    unique case (depth_i)
      DEP_565:  argb_o = from565(texel_i[15:0]);
      DEP_1555: argb_o = from1555(texel_i[15:0]);
      DEP_4444: argb_o = from4444(texel_i[15:0]);
      DEP_8888: argb_o = texel_i;
      default:  argb_o = entry_argb;
    endcase
  end

  // R7: an index never carries bits beyond the selected depth
  always_comb begin
    if (depth_i == DEP_P1) a_r7_idx1: assert (index_o[PAL_IDX_W-1:1] == '0);
    if (depth_i == DEP_P2) a_r7_idx2: assert (index_o[PAL_IDX_W-1:2] == '0);
  end
endmodule

// File: rtl/texdec_key.sv
module texdec_key
  import texdec_pkg::*;
(
  input  logic [31:0]    argb_i,
  input  logic           key_en_i,
  input  logic [KEY_W-1:0] key_i,
  output logic [31:0]    argb_o,
  output logic           hit_o
);
  assign hit_o  = key_en_i && (argb_i[KEY_W-1:0] == key_i);
  assign argb_o = hit_o ? {8'h00, argb_i[23:0]} : argb_i;
endmodule

// File: rtl/texdec_top.sv
module texdec_top
  import texdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TEXEL_W-1:0]   texel_i,
  input  logic [2:0]           depth_i,
  input  logic [1:0]           palfmt_i,
  input  logic                 key_en_i,
  input  logic [KEY_W-1:0]     key_rgb_i,
  input  logic                 pal_we_i,
  input  logic [PAL_IDX_W-1:0] pal_waddr_i,
  input  logic [ENTRY_W-1:0]   pal_wdata_i,
  output logic [31:0]          argb_o,
  output logic                 key_hit_o
);
  logic [PAL_IDX_W-1:0] pal_index;
  logic [ENTRY_W-1:0]   pal_entry;
  logic [31:0]          decoded;
  logic [31:0]          keyed;
  logic                 key_match;

  texdec_palette u_pal (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (pal_we_i),
    .waddr_i (pal_waddr_i),
    .wdata_i (pal_wdata_i),
    .raddr_i (pal_index),
    .rdata_o (pal_entry)
  );

  texdec_expand u_exp (
    .texel_i  (texel_i),
    .depth_i  (depth_e'(depth_i)),
    .palfmt_i (palfmt_e'(palfmt_i)),
    .entry_i  (pal_entry),
    .index_o  (pal_index),
    .argb_o   (decoded)
  );

  texdec_key u_key (
    .argb_i   (decoded),
    .key_en_i (key_en_i),
    .key_i    (key_rgb_i),
    .argb_o   (keyed),
    .hit_o    (key_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      argb_o    <= '0;
      key_hit_o <= 1'b0;
    end else begin
      argb_o    <= keyed;
      key_hit_o <= key_match;
    end
  end

  // R10: a keyed texel leaves with zero alpha and the key colour
  a_r10_hit_zero_alpha: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit_o |-> (argb_o[31:24] == 8'h00 && argb_o[23:0] == $past(key_rgb_i)));

  // R11: a disabled key never raises the flag
  a_r11_key_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(key_en_i)) |-> !key_hit_o);

  // R3: unkeyed 565 texels are opaque
  a_r3_opaque_565: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(depth_i) == DEP_565 && !key_hit_o) |-> argb_o[31:24] == 8'hFF);

  // R6: unkeyed 32-bit texels arrive untouched one cycle later
  a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(depth_i) == DEP_8888 && !$past(key_en_i))
      |-> argb_o == $past(texel_i));
endmodule

// File: tb/tb_texdec_top.sv
module tb_texdec_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] texel_i = '0;
  logic [2:0]  depth_i = '0;
  logic [1:0]  palfmt_i = '0;
  logic        key_en_i = 1'b0;
  logic [23:0] key_rgb_i = '0;
  logic        pal_we_i = 1'b0;
  logic [7:0]  pal_waddr_i = '0;
  logic [15:0] pal_wdata_i = '0;
  logic [31:0] argb_o;
  logic        key_hit_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] model_pal [256];

  always #2 clk = ~clk;

  texdec_top dut (.*);

  function automatic logic [7:0] up5(input int v);  return 8'((v * 33) >> 2); endfunction
  function automatic logic [7:0] up6(input int v);  return 8'((v * 65) >> 4); endfunction
  function automatic logic [7:0] up4(input int v);  return 8'(v * 17); endfunction

  function automatic logic [31:0] m16(input logic [15:0] w, input int lay);
    logic [31:0] c;
    case (lay)
      1: c = {(w >> 15) != 0 ? 8'd255 : 8'd0, up5((w >> 10) & 31), up5((w >> 5) & 31), up5(w & 31)};
      2: c = {up4(w >> 12), up4((w >> 8) & 15), up4((w >> 4) & 15), up4(w & 15)};
      default: c = {8'd255, up5(w >> 11), up6((w >> 5) & 63), up5(w & 31)};
    endcase
    return c;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] t, input int dep, input int pf);
    int bits;
    if (dep < 4) begin
      bits = 1 << dep;
      return m16(model_pal[int'(t) & ((1 << bits) - 1)], (pf == 3) ? 0 : pf);
    end
    if (dep == 7) return t;
    return m16(t[15:0], dep - 4);
  endfunction

  task automatic check(input string req, input logic [31:0] got_c, input logic got_h,
                       input logic [31:0] exp_c, input logic exp_h);
    checks++;
    if (got_c !== exp_c || got_h !== exp_h) begin
      errors++;
      $display("FAIL %s: got argb=%h hit=%b expected argb=%h hit=%b", req, got_c, got_h, exp_c, exp_h);
    end
  endtask

  task automatic drive(input logic [31:0] t, input int dep, input int pf,
                       input logic ke, input logic [23:0] k);
    texel_i = t; depth_i = 3'(dep); palfmt_i = 2'(pf); key_en_i = ke; key_rgb_i = k;
  endtask

  task automatic expect_now(input string req, input logic [31:0] t, input int dep,
                            input int pf, input logic ke, input logic [23:0] k);
    logic [31:0] c;
    logic h;
    c = model(t, dep, pf);
    h = ke && (c[23:0] == k);
    if (h) c[31:24] = 8'h00;
    @(posedge clk); @(negedge clk);
    check(req, argb_o, key_hit_o, c, h);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    drive(32'hFFFF_FFFF, 7, 0, 1'b0, '0);
    @(posedge clk); @(negedge clk);
    check("R1 in reset", argb_o, key_hit_o, 32'h0, 1'b0);
    rst_n = 1'b1;
    check("R1 after release", argb_o, key_hit_o, 32'h0, 1'b0);

    // R9: fill the whole colour table
    for (int i = 0; i < 256; i++) begin
      model_pal[i] = 16'($urandom);
      pal_we_i = 1'b1; pal_waddr_i = 8'(i); pal_wdata_i = model_pal[i];
      @(posedge clk); @(negedge clk);
    end
    pal_we_i = 1'b0;

    // R9: write then look up the same entry on the next cycle
    model_pal[8'h5A] = 16'hF81F;
    pal_we_i = 1'b1; pal_waddr_i = 8'h5A; pal_wdata_i = 16'hF81F;
    @(posedge clk); @(negedge clk);
    pal_we_i = 1'b0;
    drive(32'hABCD_005A, 3, 0, 1'b0, '0);
    expect_now("R9 fresh entry", 32'hABCD_005A, 3, 0, 1'b0, '0);

    // R2: output stays on old value until the edge
    drive(32'h1234_5678, 7, 0, 1'b0, '0);
    @(posedge clk); @(negedge clk);
    drive(32'h8765_4321, 7, 0, 1'b0, '0);
    #1;
    check("R2 held between edges", argb_o, key_hit_o, 32'h1234_5678, 1'b0);
    expect_now("R2 next edge", 32'h8765_4321, 7, 0, 1'b0, '0);

    // directed corners
    drive(32'h0000_FFFF, 4, 0, 1'b0, '0);
    expect_now("R3 565 white", 32'h0000_FFFF, 4, 0, 1'b0, '0);
    drive(32'h0000_7C00, 5, 0, 1'b0, '0);
    expect_now("R4 1555 red no alpha", 32'h0000_7C00, 5, 0, 1'b0, '0);
    drive(32'h0000_A5C3, 6, 0, 1'b0, '0);
    expect_now("R5 4444 nibbles", 32'h0000_A5C3, 6, 0, 1'b0, '0);
    drive(32'hFFFF_FFFE, 0, 3, 1'b0, '0);
    expect_now("R7 1bpp upper ignored / R8 reserved", 32'hFFFF_FFFE, 0, 3, 1'b0, '0);
    drive(32'h8012_3456, 7, 0, 1'b1, 24'h123456);
    expect_now("R10 key match", 32'h8012_3456, 7, 0, 1'b1, 24'h123456);
    drive(32'h8012_3456, 7, 0, 1'b1, 24'h123457);
    expect_now("R11 key mismatch", 32'h8012_3456, 7, 0, 1'b1, 24'h123457);
    drive(32'h8012_3456, 7, 0, 1'b0, 24'h123456);
    expect_now("R11 key disabled", 32'h8012_3456, 7, 0, 1'b0, 24'h123456);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] t;
      int dep, pf;
      logic ke;
      logic [23:0] k;
      logic [31:0] c;
      t = $urandom; dep = int'($urandom % 8); pf = int'($urandom % 4);
      ke = 1'($urandom);
      c = model(t, dep, pf);
      k = ($urandom % 3 == 0) ? c[23:0] : 24'($urandom);
      drive(t, dep, pf, ke, k);
      case (dep)
        0, 1, 2, 3: expect_now(ke ? "R7 R8 R10 palettized keyed" : "R7 R8 R11 palettized", t, dep, pf, ke, k);
        4: expect_now(ke ? "R3 R10 565 keyed" : "R3 R11 565", t, dep, pf, ke, k);
        5: expect_now(ke ? "R4 R10 1555 keyed" : "R4 R11 1555", t, dep, pf, ke, k);
        6: expect_now(ke ? "R5 R10 4444 keyed" : "R5 R11 4444", t, dep, pf, ke, k);
        default: expect_now(ke ? "R6 R10 32bpp keyed" : "R6 R11 32bpp", t, dep, pf, ke, k);
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule